// File: doc/BRIEF.md
# Burst Superframe M-Bit Multiplexer

This block owns the single M bit carried in every burst of a ping-pong burst line. Four bursts make one superframe, and the four M slots in that superframe are shared by three channels. Slot 0 is a framing mark that the line coder sends as a code violation. Slots 1 and 3 carry the two bits of a T channel, which runs at twice the S-channel rate. Slot 2 carries one S bit.

On the send side, T and S words are offered over valid/ready handshakes. The block emits one M bit per burst strobe, and it raises a flag that tells the line coder to break the alternate-mark rule for the framing slot.

On the receive side, the block watches the M bits together with a code-violation detect flag from the line decoder. It finds the superframe phase from the violations, holds lock while they keep arriving every fourth burst, and hands out the received T and S bits once per superframe.

Top module: `msf_mux`

## Requirements
- R1: Slot 0 is the burst strobe that follows reset or every fourth strobe after it. On that strobe `tx_m_bit` becomes 1 and `tx_force_cv` becomes 1. On the strobes for slots 1, 2 and 3, `tx_force_cv` becomes 0. Both outputs are registered and hold their value between strobes.
- R2: Slot 1 carries bit 1 (MSB) of the active T word. Slot 2 carries the active S bit. Slot 3 carries bit 0 of the active T word.
- R3: The ready output for T (and separately for S) is 1 whenever no accepted word is waiting. A word is accepted when valid and ready are both 1 at a clock edge, and ready then stays 0 until the next slot-0 strobe. At that strobe the waiting word becomes active for slots 1 to 3 of that superframe. Valid asserted while ready is 0 has no effect.
- R4: If no new word was accepted before a slot-0 strobe, the superframe repeats the previous active T and S values.
- R5: The receiver locks after two code violations that fall exactly four received bursts apart. A violation at any other spacing restarts the search from that violation. Once locked, the receive slot that follows the violation is slot 1.
- R6: While locked, the receiver captures the slot-1, slot-2 and slot-3 M bits. On the slot-3 burst it drives `rx_t_data` = {slot1, slot3} and `rx_s_data` = slot2, with `rx_t_valid` and `rx_s_valid` high for exactly one cycle. A slot-3 burst that itself carries a code violation delivers nothing.
- R7: While unlocked, `rx_t_valid` and `rx_s_valid` stay 0.
- R8: While locked, each slot-0 burst without a violation, and each violation outside slot 0, counts as an error. A violation in slot 0 clears the error count. Lock is lost when LOSS_MISSES errors (default 2) accumulate, and a single error keeps lock.
- R9: After reset: `tx_m_bit`=0, `tx_force_cv`=0, both ready outputs 1, `rx_locked`=0, both valid outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_stb | input | 1 | One-cycle strobe per transmitted burst |
| tx_t_data | input | 2 | T word to send |
| tx_t_valid | input | 1 | T word offered |
| tx_t_ready | output | 1 | T word can be accepted |
| tx_s_data | input | 1 | S bit to send |
| tx_s_valid | input | 1 | S bit offered |
| tx_s_ready | output | 1 | S bit can be accepted |
| tx_m_bit | output | 1 | M bit for the current burst |
| tx_force_cv | output | 1 | Tells the line coder to send a code violation in the M slot |
| rx_stb | input | 1 | One-cycle strobe per received burst |
| rx_m_bit | input | 1 | Received M bit |
| rx_cv | input | 1 | Code violation detected in the received M slot |
| rx_locked | output | 1 | Superframe lock |
| rx_t_data | output | 2 | Received T word {slot1, slot3} |
| rx_t_valid | output | 1 | One-cycle pulse with rx_t_data |
| rx_s_data | output | 1 | Received S bit |
| rx_s_valid | output | 1 | One-cycle pulse with rx_s_data |

## Verification
The send path is looped back into the receive path. A sequence of T/S words then runs through it, including superframes with no new word, so that a wrong slot order, a swapped T bit and a failure to repeat stale data each show up as a distinct mismatch. Separate directed receive patterns cover these cases: violations five bursts apart, which must not lock; violations four apart, which must lock; a single missing mark, which must keep lock; two missing marks, or a misplaced violation, which must drop lock. A handshake offered while a word is already waiting must be ignored.

// File: rtl/msf_pkg.sv
package msf_pkg;
  localparam int POS_W = 2;
  typedef logic [POS_W-1:0] sf_pos_t;
  localparam sf_pos_t POS_MARK = 2'd0;
  localparam sf_pos_t POS_T_HI = 2'd1;
  localparam sf_pos_t POS_S    = 2'd2;
  localparam sf_pos_t POS_T_LO = 2'd3;
  localparam int T_W = 2;
endpackage

// File: rtl/msf_tx.sv
module msf_tx
  import msf_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           burst_stb,
  input  logic [T_W-1:0] t_data,
  input  logic           t_valid,
  output logic           t_ready,
  input  logic           s_data,
  input  logic           s_valid,
  output logic           s_ready,
  output logic           m_bit,
  output logic           force_cv
);
  sf_pos_t        pos;
  logic [T_W-1:0] t_next, t_act;
  logic           t_pend, s_next, s_pend, s_act;
  logic           sf_start;

  assign sf_start = burst_stb && (pos == POS_MARK);
  assign t_ready  = !t_pend;
  assign s_ready  = !s_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= POS_MARK;
      t_next <= '0; t_act <= '0; t_pend <= 1'b0;
      s_next <= 1'b0; s_act <= 1'b0; s_pend <= 1'b0;
      m_bit <= 1'b0; force_cv <= 1'b0;
    end else begin
      if (t_valid && !t_pend) begin
        t_next <= t_data;
        t_pend <= 1'b1;
      end
      if (s_valid && !s_pend) begin
        s_next <= s_data;
        s_pend <= 1'b1;
      end
      if (sf_start && t_pend) begin
        t_act  <= t_next;
        t_pend <= 1'b0;
      end
      if (sf_start && s_pend) begin
        s_act  <= s_next;
        s_pend <= 1'b0;
      end
      if (burst_stb) begin
        pos <= pos + 2'd1;
        force_cv <= (pos == POS_MARK);
        case (pos)
          POS_MARK: m_bit <= 1'b1;
          POS_T_HI: m_bit <= t_act[1];
          POS_S:    m_bit <= s_act;
          default:  m_bit <= t_act[0];
        endcase
      end
    end
  end
endmodule

// File: rtl/msf_rx.sv
module msf_rx
  import msf_pkg::*;
#(
  parameter int LOCK_HITS   = 2,
  parameter int LOSS_MISSES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_stb,
  input  logic           rx_m_bit,
  input  logic           rx_cv,
  output logic           locked,
  output logic [T_W-1:0] t_data,
  output logic           t_valid,
  output logic           s_data,
  output logic           s_valid
);
  localparam int HIT_W  = $clog2(LOCK_HITS + 1);
  localparam int MISS_W = $clog2(LOSS_MISSES + 1);

  sf_pos_t           pos;
  logic [HIT_W-1:0]  hits;
  logic [MISS_W-1:0] misses;
  logic              t_hi, s_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= POS_MARK; hits <= '0; misses <= '0; locked <= 1'b0;
      t_hi <= 1'b0; s_bit <= 1'b0;
      t_data <= '0; s_data <= 1'b0; t_valid <= 1'b0; s_valid <= 1'b0;
    end else begin
      t_valid <= 1'b0;
      s_valid <= 1'b0;
      if (rx_stb) begin
        pos <= pos + 2'd1;
        if (!locked) begin
          if (rx_cv) begin
            pos <= POS_T_HI;
            if (hits != '0 && pos == POS_MARK) begin
              if (hits == HIT_W'(LOCK_HITS - 1)) begin
                locked <= 1'b1;
                hits   <= '0;
                misses <= '0;
              end else begin
                hits <= hits + 1'b1;
              end
            end else begin
              hits <= HIT_W'(1);
            end
          end else if (pos == POS_MARK) begin
            hits <= '0;
          end
        end else begin
          if (pos == POS_MARK && rx_cv) begin
            misses <= '0;
          end else if (pos == POS_MARK || rx_cv) begin
            if (misses == MISS_W'(LOSS_MISSES - 1)) begin
              locked <= 1'b0;
              misses <= '0;
              hits   <= '0;
            end else begin
              misses <= misses + 1'b1;
            end
          end
          case (pos)
            POS_T_HI: t_hi  <= rx_m_bit;
            POS_S:    s_bit <= rx_m_bit;
            POS_T_LO: if (!rx_cv) begin
              t_data  <= {t_hi, rx_m_bit};
              s_data  <= s_bit;
              t_valid <= 1'b1;
              s_valid <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/msf_mux.sv
module msf_mux
  import msf_pkg::*;
#(
  parameter int LOCK_HITS   = 2,
  parameter int LOSS_MISSES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           burst_stb,
  input  logic [T_W-1:0] tx_t_data,
  input  logic           tx_t_valid,
  output logic           tx_t_ready,
  input  logic           tx_s_data,
  input  logic           tx_s_valid,
  output logic           tx_s_ready,
  output logic           tx_m_bit,
  output logic           tx_force_cv,
  input  logic           rx_stb,
  input  logic           rx_m_bit,
  input  logic           rx_cv,
  output logic           rx_locked,
  output logic [T_W-1:0] rx_t_data,
  output logic           rx_t_valid,
  output logic           rx_s_data,
  output logic           rx_s_valid
);
  msf_tx u_tx (
    .clk(clk), .rst(rst), .burst_stb(burst_stb),
    .t_data(tx_t_data), .t_valid(tx_t_valid), .t_ready(tx_t_ready),
    .s_data(tx_s_data), .s_valid(tx_s_valid), .s_ready(tx_s_ready),
    .m_bit(tx_m_bit), .force_cv(tx_force_cv)
  );

  msf_rx #(.LOCK_HITS(LOCK_HITS), .LOSS_MISSES(LOSS_MISSES)) u_rx (
    .clk(clk), .rst(rst), .rx_stb(rx_stb), .rx_m_bit(rx_m_bit), .rx_cv(rx_cv),
    .locked(rx_locked), .t_data(rx_t_data), .t_valid(rx_t_valid),
    .s_data(rx_s_data), .s_valid(rx_s_valid)
  );
endmodule

// File: rtl/msf_mux_chk.sv
module msf_mux_chk (
  input logic clk,
  input logic rst,
  input logic burst_stb,
  input logic tx_m_bit,
  input logic tx_force_cv,
  input logic rx_stb,
  input logic rx_cv,
  input logic rx_locked,
  input logic rx_t_valid,
  input logic rx_s_valid
);
  // R1
  mark_is_one_chk: assert property (@(posedge clk) disable iff (rst)
    tx_force_cv |-> tx_m_bit);
  // R1
  cv_single_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (burst_stb && tx_force_cv) |=> !tx_force_cv);
  // R1
  m_held_chk: assert property (@(posedge clk) disable iff (rst)
    !burst_stb |=> $stable(tx_m_bit));
  // R5
  lock_from_cv_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_locked) |-> ($past(rx_stb) && $past(rx_cv)));
  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_t_valid |=> !rx_t_valid);
  // R6
  valid_pair_chk: assert property (@(posedge clk) disable iff (rst)
    rx_t_valid == rx_s_valid);
  // R7
  valid_locked_chk: assert property (@(posedge clk) disable iff (rst)
    rx_t_valid |-> rx_locked);
endmodule

bind msf_mux msf_mux_chk u_chk (
  .clk(clk), .rst(rst), .burst_stb(burst_stb), .tx_m_bit(tx_m_bit),
  .tx_force_cv(tx_force_cv), .rx_stb(rx_stb), .rx_cv(rx_cv),
  .rx_locked(rx_locked), .rx_t_valid(rx_t_valid), .rx_s_valid(rx_s_valid)
);

// File: tb/msf_mux_test.sv
module msf_mux_test;
  logic clk = 0, rst = 1;
  logic burst_stb = 0, tx_t_valid = 0, tx_s_valid = 0, tx_s_data = 0;
  logic [1:0] tx_t_data = 0;
  logic rx_stb = 0, drv_m = 0, drv_cv = 0, lb = 0;
  logic tx_t_ready, tx_s_ready, tx_m_bit, tx_force_cv;
  logic rx_locked, rx_t_valid, rx_s_data, rx_s_valid;
  logic [1:0] rx_t_data;
  logic rx_m_w, rx_cv_w;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  assign rx_m_w  = lb ? tx_m_bit : drv_m;
  assign rx_cv_w = lb ? tx_force_cv : drv_cv;

  msf_mux uut (
    .clk(clk), .rst(rst), .burst_stb(burst_stb),
    .tx_t_data(tx_t_data), .tx_t_valid(tx_t_valid), .tx_t_ready(tx_t_ready),
    .tx_s_data(tx_s_data), .tx_s_valid(tx_s_valid), .tx_s_ready(tx_s_ready),
    .tx_m_bit(tx_m_bit), .tx_force_cv(tx_force_cv),
    .rx_stb(rx_stb), .rx_m_bit(rx_m_w), .rx_cv(rx_cv_w),
    .rx_locked(rx_locked), .rx_t_data(rx_t_data), .rx_t_valid(rx_t_valid),
    .rx_s_data(rx_s_data), .rx_s_valid(rx_s_valid)
  );

  // {offer, t[1:0], s}
  localparam logic [3:0] VEC [6] = '{4'b1101, 4'b1010, 4'b0000, 4'b1111, 4'b0000, 4'b1000};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic offer(input logic [1:0] t, input logic s);
    @(negedge clk) tx_t_valid = 1; tx_s_valid = 1; tx_t_data = t; tx_s_data = s;
    @(negedge clk) tx_t_valid = 0; tx_s_valid = 0;
  endtask

  task automatic tx_burst(output logic m, output logic cv);
    @(negedge clk) burst_stb = 1;
    @(negedge clk) burst_stb = 0; m = tx_m_bit; cv = tx_force_cv;
    if (lb) rx_stb = 1;
    @(negedge clk) rx_stb = 0;
  endtask

  task automatic rx_burst(input logic m, input logic cv);
    @(negedge clk) rx_stb = 1; drv_m = m; drv_cv = cv;
    @(negedge clk) rx_stb = 0; drv_m = 0; drv_cv = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic m, cv;
    logic [1:0] cur_t;
    logic cur_s;
    do_reset();
    // R9 reset state
    check("R9 m", tx_m_bit, 0);
    check("R9 cv", tx_force_cv, 0);
    check("R9 t_ready", tx_t_ready, 1);
    check("R9 s_ready", tx_s_ready, 1);
    check("R9 locked", rx_locked, 0);
    check("R9 valid", rx_t_valid | rx_s_valid, 0);

    // Loopback vector walk: R1 R2 R3 R4 R6
    lb = 1; cur_t = 0; cur_s = 0;
    for (int k = 0; k < 6; k++) begin
      if (VEC[k][3]) begin
        offer(VEC[k][2:1], VEC[k][0]);
        cur_t = VEC[k][2:1]; cur_s = VEC[k][0];
        check("R3 ready low while waiting", tx_t_ready, 0);
      end
      tx_burst(m, cv);
      check("R1 mark m", m, 1);
      check("R1 mark cv", cv, 1);
      if (k == 1) check("R5 lock in loopback", rx_locked, 1);
      tx_burst(m, cv);
      check("R2 slot1 T msb", m, cur_t[1]);
      check("R1 slot1 no cv", cv, 0);
      tx_burst(m, cv);
      check(VEC[k][3] ? "R2 slot2 S" : "R4 repeat S", m, cur_s);
      tx_burst(m, cv);
      check(VEC[k][3] ? "R2 slot3 T lsb" : "R4 repeat T", m, cur_t[0]);
      check("R6 rx valid", rx_t_valid & rx_s_valid, k >= 1);
      if (k >= 1) begin
        check("R6 rx T word", rx_t_data, cur_t);
        check("R6 rx S bit", rx_s_data, cur_s);
      end
      @(negedge clk);
      check("R6 single pulse", rx_t_valid, 0);
    end

    // R3: offer while a word waits is ignored
    lb = 0;
    do_reset();
    offer(2'b10, 1'b0);
    offer(2'b01, 1'b1);
    tx_burst(m, cv);
    tx_burst(m, cv); check("R3 ignored T msb", m, 1);
    tx_burst(m, cv); check("R3 ignored S", m, 0);
    tx_burst(m, cv); check("R3 ignored T lsb", m, 0);

    // R5: spacing 5 does not lock, spacing 4 locks
    do_reset();
    rx_burst(0, 1);
    repeat (4) rx_burst(0, 0);
    rx_burst(0, 1);
    check("R5 spacing 5 no lock", rx_locked, 0);
    repeat (3) rx_burst(0, 0);
    rx_burst(0, 1);
    check("R5 spacing 4 locks", rx_locked, 1);
    rx_burst(1, 0); rx_burst(0, 0); rx_burst(1, 0);
    check("R6 valid", rx_t_valid, 1);
    check("R6 T word", rx_t_data, 3);
    check("R6 S bit", rx_s_data, 0);
    // R8: one miss keeps lock
    rx_burst(0, 0);
    check("R8 single miss keeps lock", rx_locked, 1);
    rx_burst(0, 0); rx_burst(1, 0); rx_burst(0, 0);
    check("R6 T word after miss", rx_t_data, 0);
    check("R6 S after miss", rx_s_data, 1);
    rx_burst(0, 0);
    check("R8 second miss drops lock", rx_locked, 0);
    rx_burst(1, 0); rx_burst(1, 0); rx_burst(0, 0);
    check("R7 no valid unlocked", rx_t_valid | rx_s_valid, 0);

    // R8: misplaced violations drop lock
    do_reset();
    rx_burst(0, 1); repeat (3) rx_burst(0, 0); rx_burst(0, 1);
    check("R5 relock", rx_locked, 1);
    rx_burst(0, 1);
    check("R8 one misplaced keeps lock", rx_locked, 1);
    rx_burst(0, 0);
    rx_burst(1, 1);
    check("R8 misplaced drop", rx_locked, 0);
    check("R6 cv slot3 no data", rx_t_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule